// File: doc/BRIEF.md
# Two-Byte Event Handshake Link

This block joins a scanning controller, which produces events, to a host processor that consumes them. Each event crosses an 8-bit parallel path as a pair of bytes.

For the first byte, the sender presents the byte and raises a strobe. The block captures the byte and sets a ready flag. While the flag is set, an active-low interrupt and an active-low ready line toward the host are both asserted. The host read clears the flag. It also drives an active-low acknowledge back to the sender, which then strobes the second byte in the same way. Reading the second byte returns the link to idle.

The host holds an active-low busy line from the start of its interrupt routine until the second byte is taken. While busy is low, the block refuses to start a new event. The same busy level is passed to the sender as a hold signal that freezes its scanning. A strobe that arrives while a byte is still waiting is reported as an overrun, and the waiting byte is kept.

The controller has four states:
- `ST_IDLE`: no byte is pending.
- `ST_FIRST_RDY`: the first byte is waiting for the host.
- `ST_WAIT_SECOND`: the first byte has been taken and the acknowledge is low.
- `ST_SECOND_RDY`: the second byte is waiting for the host.

The transitions are:
- `ST_IDLE` to `ST_FIRST_RDY`: a strobe arrives while busy is high.
- `ST_FIRST_RDY` to `ST_WAIT_SECOND`: the host reads.
- `ST_WAIT_SECOND` to `ST_SECOND_RDY`: a strobe arrives.
- `ST_SECOND_RDY` to `ST_IDLE`: the host reads.
- Any state to `ST_IDLE`: reset.

Top module: `evt_pair_link`

## Requirements
- R1: After reset, and after any later reset, the block is idle with `host_irq_n`, `host_rdy_n` and `snd_ack_n` high, and with `host_second` and `overrun` low.
- R2: In idle with `host_busy_n` high, a rising edge of `snd_strobe` captures `snd_data`. On the next clock, `host_rdy_n` and `host_irq_n` are low, `host_data` shows the captured byte and `host_second` is 0.
- R3: A rising edge of `host_rd` while the first byte waits clears the ready flag, so `host_rdy_n` and `host_irq_n` go high on the next clock. On that same clock `snd_ack_n` goes low and `host_data` is unchanged.
- R4: While `snd_ack_n` is low, a rising strobe captures the second byte whatever the level of `host_busy_n`. On the next clock `snd_ack_n` is high, `host_rdy_n` is low and `host_second` is 1.
- R5: A host read of the second byte returns the link to idle on the next clock, with ready and acknowledge both high and `host_second` at 0.
- R6: In idle with `host_busy_n` low, a strobe is ignored: ready stays high and `host_data` is unchanged. `snd_hold_n` always equals `host_busy_n`.
- R7: A strobe while a byte is waiting makes `overrun` high for exactly one clock. The waiting byte and the state are kept.
- R8: A host read while no byte is waiting has no effect on state or data.
- R9: When a read and a strobe rise in the same cycle while a byte waits, the read is honoured and the strobe is reported as an overrun.
- R10: Only rising edges of `snd_strobe` and `host_rd` act. A level held high causes no further capture and no further read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| snd_data | input | 8 | Byte offered by the sender |
| snd_strobe | input | 1 | Sender strobe; its rising edge offers a byte |
| snd_ack_n | output | 1 | Low while the sender should offer the second byte |
| snd_hold_n | output | 1 | Scan hold toward the sender; follows host busy |
| host_rd | input | 1 | Host read; its rising edge takes the waiting byte |
| host_busy_n | input | 1 | Low while the host is handling an event |
| host_data | output | 8 | Captured byte |
| host_irq_n | output | 1 | Active-low interrupt; low while a byte waits |
| host_rdy_n | output | 1 | Active-low ready status |
| host_second | output | 1 | High while the waiting byte is the second of the pair |
| overrun | output | 1 | One-clock pulse when a strobe meets a waiting byte |

## Verification
A host read and a sender strobe can both land on the edge where a byte is still waiting. In that case the state must advance for the read while the strobe is flagged as an overrun.

The bench provokes this by raising `host_rd` and `snd_strobe` on the same falling edge while the first byte waits. On the next clock it expects:
- ready high and acknowledge low;
- the old byte still on `host_data`;
- `overrun` high.

It also checks that a strobe held high through that read is not taken again later.

// File: rtl/evt_link_pkg.sv
package evt_link_pkg;
    localparam int LINK_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_FIRST_RDY   = 2'd1,
        ST_WAIT_SECOND = 2'd2,
        ST_SECOND_RDY  = 2'd3
    } link_state_t;
endpackage

// File: rtl/evt_rise_det.sv
module evt_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic din_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) din_q <= 1'b0;
        else        din_q <= din;
    end

    assign rise = din & ~din_q;

    // R10: a level held high yields no edge
    assert_no_repeat_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/evt_link_fsm.sv
module evt_link_fsm
    import evt_link_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stb_evt,
    input  logic rd_evt,
    input  logic busy_n,
    output logic load,
    output logic rdy_n,
    output logic ack_n,
    output logic second,
    output logic overrun
);
    link_state_t state, state_nx;
    logic        pending;

    assign pending = (state == ST_FIRST_RDY) || (state == ST_SECOND_RDY);

    always_comb begin
        state_nx = state;
        load     = 1'b0;
        unique case (state)
            ST_IDLE: if (stb_evt && busy_n) begin
                state_nx = ST_FIRST_RDY;
                load     = 1'b1;
            end
            ST_FIRST_RDY:   if (rd_evt) state_nx = ST_WAIT_SECOND;
            ST_WAIT_SECOND: if (stb_evt) begin
                state_nx = ST_SECOND_RDY;
                load     = 1'b1;
            end
            ST_SECOND_RDY:  if (rd_evt) state_nx = ST_IDLE;
            default:        state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            overrun <= 1'b0;
        end else begin
            state   <= state_nx;
            overrun <= stb_evt && pending;
        end
    end

    always_comb begin
        rdy_n  = 1'b1;
        ack_n  = 1'b1;
        second = 1'b0;
        unique case (state)
            ST_IDLE:        ;
            ST_FIRST_RDY:   rdy_n = 1'b0;
            ST_WAIT_SECOND: ack_n = 1'b0;
            ST_SECOND_RDY: begin
                rdy_n  = 1'b0;
                second = 1'b1;
            end
            default:        ;
        endcase
    end

    assert_start_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && stb_evt && busy_n) |=> (!rdy_n && !second));
    assert_first_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIRST_RDY && rd_evt) |=> (rdy_n && !ack_n));
    assert_second_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && stb_evt) |=> (ack_n && !rdy_n && second));
    assert_pair_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SECOND_RDY && rd_evt) |=> (state == ST_IDLE));
    assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !busy_n) |=> rdy_n);
    assert_overrun_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_evt && !rdy_n) |=> overrun);
    assert_idle_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_n && rd_evt && !stb_evt) |=> $stable(state));
endmodule

// File: rtl/evt_byte_hold.sv
module evt_byte_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    dout <= '0;
        else if (load) dout <= din;
    end

    // R7 / R8: the held byte changes only on a capture
    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dout));
endmodule

// File: rtl/evt_pair_link.sv
module evt_pair_link
    import evt_link_pkg::*;
#(
    parameter int DATA_W = LINK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] snd_data,
    input  logic              snd_strobe,
    output logic              snd_ack_n,
    output logic              snd_hold_n,
    input  logic              host_rd,
    input  logic              host_busy_n,
    output logic [DATA_W-1:0] host_data,
    output logic              host_irq_n,
    output logic              host_rdy_n,
    output logic              host_second,
    output logic              overrun
);
    logic stb_evt, rd_evt, load, rdy_n;

    evt_rise_det i_stb_rise (.clk(clk), .rst_n(rst_n), .din(snd_strobe), .rise(stb_evt));
    evt_rise_det i_rd_rise  (.clk(clk), .rst_n(rst_n), .din(host_rd),    .rise(rd_evt));

    evt_link_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .stb_evt(stb_evt), .rd_evt(rd_evt),
        .busy_n(host_busy_n), .load(load), .rdy_n(rdy_n), .ack_n(snd_ack_n),
        .second(host_second), .overrun(overrun)
    );

    evt_byte_hold #(.W(DATA_W)) i_hold (
        .clk(clk), .rst_n(rst_n), .load(load), .din(snd_data), .dout(host_data)
    );

    assign host_rdy_n = rdy_n;
    assign host_irq_n = rdy_n;
    assign snd_hold_n = host_busy_n;

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (host_irq_n && snd_ack_n && !overrun));
endmodule

// File: tb/test_evt_pair_link.sv
module test_evt_pair_link;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] snd_data = 8'h00;
    logic       snd_strobe = 1'b0;
    logic       host_rd = 1'b0;
    logic       host_busy_n = 1'b1;
    logic       snd_ack_n, snd_hold_n, host_irq_n, host_rdy_n, host_second, overrun;
    logic [7:0] host_data;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    evt_pair_link i_evt_pair_link (
        .clk(clk), .rst_n(rst_n), .snd_data(snd_data), .snd_strobe(snd_strobe),
        .snd_ack_n(snd_ack_n), .snd_hold_n(snd_hold_n), .host_rd(host_rd),
        .host_busy_n(host_busy_n), .host_data(host_data), .host_irq_n(host_irq_n),
        .host_rdy_n(host_rdy_n), .host_second(host_second), .overrun(overrun)
    );

    // fields: req[26:23] op[22:21] busy_n[20] data[19:12] rdy_n[11] ack_n[10] exp_data[9:2] second[1] ovr[0]
    // op: 0 strobe, 1 read
    localparam int NV = 11;
    localparam logic [26:0] VEC [NV] = '{
        {4'd2, 2'd0, 1'b1, 8'hA5, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0}, // R2 first byte
        {4'd7, 2'd0, 1'b1, 8'h3C, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b1}, // R7 overrun keeps byte
        {4'd3, 2'd1, 1'b1, 8'h00, 1'b1, 1'b0, 8'hA5, 1'b0, 1'b0}, // R3 read first
        {4'd8, 2'd1, 1'b1, 8'h00, 1'b1, 1'b0, 8'hA5, 1'b0, 1'b0}, // R8 read ignored
        {4'd4, 2'd0, 1'b0, 8'h5A, 1'b0, 1'b1, 8'h5A, 1'b1, 1'b0}, // R4 second despite busy
        {4'd5, 2'd1, 1'b0, 8'h00, 1'b1, 1'b1, 8'h5A, 1'b0, 1'b0}, // R5 back to idle
        {4'd6, 2'd0, 1'b0, 8'h77, 1'b1, 1'b1, 8'h5A, 1'b0, 1'b0}, // R6 busy blocks start
        {4'd2, 2'd0, 1'b1, 8'h81, 1'b0, 1'b1, 8'h81, 1'b0, 1'b0}, // R2 new event
        {4'd3, 2'd1, 1'b1, 8'h00, 1'b1, 1'b0, 8'h81, 1'b0, 1'b0}, // R3
        {4'd4, 2'd0, 1'b1, 8'hC3, 1'b0, 1'b1, 8'hC3, 1'b1, 1'b0}, // R4
        {4'd5, 2'd1, 1'b1, 8'h00, 1'b1, 1'b1, 8'hC3, 1'b0, 1'b0}  // R5
    };

    task automatic chk(input int req, input logic rdy, input logic ack,
                       input logic [7:0] d, input logic sec, input logic ovr);
        checks++;
        if (host_rdy_n !== rdy || host_irq_n !== rdy || snd_ack_n !== ack ||
            host_data !== d || host_second !== sec || overrun !== ovr) begin
            errors++;
            $display("FAIL R%0d: got rdy_n=%b irq_n=%b ack_n=%b data=%h second=%b ovr=%b; expected rdy_n=%b irq_n=%b ack_n=%b data=%h second=%b ovr=%b",
                     req, host_rdy_n, host_irq_n, snd_ack_n, host_data, host_second, overrun,
                     rdy, rdy, ack, d, sec, ovr);
        end
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(1, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0); // R1 reset state
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            host_busy_n = VEC[i][20];
            snd_data    = VEC[i][19:12];
            if (VEC[i][22:21] == 2'd0) snd_strobe = 1'b1;
            else                       host_rd    = 1'b1;
            @(negedge clk);
            chk(int'(VEC[i][26:23]), VEC[i][11], VEC[i][10], VEC[i][9:2], VEC[i][1], VEC[i][0]);
            snd_strobe = 1'b0;
            host_rd    = 1'b0;
            @(negedge clk);
        end

        // R6: hold output follows busy
        host_busy_n = 1'b0; #1;
        checks++;
        if (snd_hold_n !== 1'b0) begin
            errors++; $display("FAIL R6: got hold_n=%b expected 0", snd_hold_n);
        end
        host_busy_n = 1'b1;
        @(negedge clk);

        // R9: read and strobe together while first byte waits
        snd_data = 8'h12; snd_strobe = 1'b1;
        @(negedge clk); snd_strobe = 1'b0;
        @(negedge clk);
        snd_data = 8'hEE; snd_strobe = 1'b1; host_rd = 1'b1;
        @(negedge clk);
        chk(9, 1'b1, 1'b0, 8'h12, 1'b0, 1'b1); // R9
        host_rd = 1'b0;
        @(negedge clk);
        chk(7, 1'b1, 1'b0, 8'h12, 1'b0, 1'b0); // R7 pulse lasts one clock; strobe still high
        // R10: strobe held high is not taken again as the second byte
        repeat (2) @(negedge clk);
        chk(10, 1'b1, 1'b0, 8'h12, 1'b0, 1'b0);
        snd_strobe = 1'b0;
        @(negedge clk);
        snd_data = 8'h34; snd_strobe = 1'b1;
        @(negedge clk);
        chk(4, 1'b0, 1'b1, 8'h34, 1'b1, 1'b0); // R4
        host_rd = 1'b1;
        @(negedge clk);
        chk(5, 1'b1, 1'b1, 8'h34, 1'b0, 1'b0); // R5
        repeat (2) @(negedge clk);
        chk(10, 1'b1, 1'b1, 8'h34, 1'b0, 1'b0); // R10 held read and strobe do nothing
        host_rd = 1'b0; snd_strobe = 1'b0;
        @(negedge clk);

        // R1: mid-run reset returns to idle
        snd_data = 8'h9F; snd_strobe = 1'b1;
        @(negedge clk); snd_strobe = 1'b0;
        host_rd = 1'b1;
        @(negedge clk); host_rd = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(1, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(1, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule